// File: doc/BRIEF.md
# Serial-Clocked 64x16 EEPROM Slave Model

This block is a synthesizable behavioural model of a small serial EEPROM that holds 64 words of 16 bits (1 Kbit in total) behind a three-wire serial link: a select line, a serial clock and a data input, plus one data output with its own output enable. The model runs on a fast system clock. The select, serial clock and data-in pins are taken to be already synchronous to that clock, and each serial clock level lasts at least one system clock. The link is specified with a serial clock of up to 1 MHz, well below the system clock. Every pin is a plain control or data pin. There is no valid/ready stream at the boundary, so back-pressure does not apply: the serial master paces every bit.

A command opens with a start bit of 1. A 2-bit opcode and a 6-bit address follow, and all bits are sampled most significant first on rising serial clock edges. Reads shift a word out. Writes, single-word erases, whole-array erases and whole-array writes arm a programming operation. The programming operation starts when select falls and runs for a fixed number of system clocks. During that time the data output shows a busy/ready status whenever select is high. Programming commands only take effect after a write-enable command has been received.

Top module: `mwe_eeprom`

## Requirements
- R1: After reset the data output enable is low, the array holds zero in every word, and the device is write-disabled.
- R2: A command starts at the first rising serial clock with data-in 1 while select is high; 0 bits before it are ignored. Opcode 10 reads, 01 writes, 11 erases one word, and 00 selects by the two top address bits: 11 write-enable, 00 write-disable, 10 erase-all, 01 write-all.
- R3: After the last address bit of a read, the output shows a 0 dummy bit and then the 16 word bits MSB first, each one advancing on a rising serial clock edge. After the last bit, the output holds it until select falls.
- R4: A write takes 16 data bits MSB first. Programming starts on the select falling edge that follows the last bit, and it replaces the word without a prior erase. Busy lasts exactly PROG_CYCLES system clocks.
- R5: Erase sets the addressed word to FFFF. Erase-all sets every word to FFFF. Write-all writes its 16 data bits to every word.
- R6: While write-disabled, write, erase, erase-all and write-all change no word and start no busy period. Write-enable and write-disable take effect at the last address bit.
- R7: While busy and select is high, the output is driven low. Whenever select is low, the output enable is low. Toggling select during busy does not disturb programming.
- R8: After programming ends, select high drives the output high (ready). This persists across select toggles until a start bit is clocked in, which clears it and begins a command.
- R9: Serial clock edges arriving while busy are discarded, including any command they carry.
- R10: A rising serial clock after the last bit of a programming command, before select falls, cancels that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled on clk |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out or busy/ready status |
| dout_oe | output | 1 | Output enable for dout; low means tri-stated |

## Verification
The model sees a serial clock rise at the first system clock edge where sk is high after being low, so each output bit and each decoded command takes effect one system clock after that edge. The busy period begins one clock after select is sampled low and ends PROG_CYCLES clocks later, and the memory update lands at that same edge. The bench changes inputs 1 ns after a falling clock edge, holds each serial level for two system clocks and compares outputs at falling edges. Every due value has therefore settled through its single register stage before it is compared. A behavioural model in the bench, built from bit queues and a countdown integer, predicts the output and output enable for each cycle. Directed reads then confirm the word values.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DATA, ST_READ, ST_ARMED, ST_HOLD
  } fsm_t;

  typedef enum logic [1:0] {
    PK_WRITE, PK_ERASE, PK_WRALL, PK_ERALL
  } prog_t;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_WDIS  = 2'b00;
  localparam logic [1:0] EXT_WRALL = 2'b01;
  localparam logic [1:0] EXT_ERALL = 2'b10;
  localparam logic [1:0] EXT_WEN   = 2'b11;
endpackage

// File: rtl/mwe_pin_edge.sv
module mwe_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  output logic sk_rise,
  output logic cs_fall
);
  logic sk_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
    end
  end

  assign sk_rise = sk & ~sk_q;
  assign cs_fall = ~cs & cs_q;
endmodule

// File: rtl/mwe_cmd_fsm.sv
module mwe_cmd_fsm import mwe_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              di,
  input  logic              busy,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [WORD_W-1:0] wdata,
  output prog_t             launch_kind,
  output logic              launch,
  output logic              start_seen,
  output logic              rd_active,
  output logic              rd_bit,
  output logic              idle
);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int CNT_W = $clog2(HDR_W + WORD_W + 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] WORD_CNT  = CNT_W'(WORD_W);

  fsm_t              state;
  logic [HDR_W-1:0]  hdr;
  logic [HDR_W-1:0]  hdr_nx;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] dsr;
  prog_t             kind;
  logic              wen;
  logic              rbit;
  logic              step;
  logic [1:0]        opc_nx;
  logic [1:0]        ext_nx;

  assign hdr_nx  = {hdr[HDR_W-2:0], di};
  assign opc_nx  = hdr_nx[HDR_W-1 -: 2];
  assign ext_nx  = hdr_nx[ADDR_W-1 -: 2];
  assign step    = cs & sk_rise & ~busy;

  assign rd_addr     = hdr_nx[ADDR_W-1:0];
  assign prog_addr   = hdr[ADDR_W-1:0];
  assign wdata       = dsr;
  assign launch_kind = kind;
  assign launch      = cs_fall & (state == ST_ARMED) & wen & ~busy;
  assign start_seen  = step & (state == ST_IDLE) & di;
  assign rd_active   = (state == ST_READ);
  assign rd_bit      = rbit;
  assign idle        = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      hdr   <= '0;
      cnt   <= '0;
      dsr   <= '0;
      kind  <= PK_WRITE;
      wen   <= 1'b0;
      rbit  <= 1'b0;
    end else if (!cs) begin
      state <= ST_IDLE;
    end else if (step) begin
      unique case (state)
        ST_IDLE: begin
          if (di) begin
            state <= ST_HDR;
            cnt   <= '0;
            hdr   <= '0;
          end
        end
        ST_HDR: begin
          hdr <= hdr_nx;
          cnt <= cnt + 1'b1;
          if (cnt == HDR_LAST) begin
            cnt <= '0;
            unique case (opc_nx)
              OPC_READ: begin
                state <= ST_READ;
                rbit  <= 1'b0;
                dsr   <= rdata;
              end
              OPC_WRITE: begin
                state <= ST_DATA;
                kind  <= PK_WRITE;
              end
              OPC_ERASE: begin
                state <= ST_ARMED;
                kind  <= PK_ERASE;
              end
              default: begin
                unique case (ext_nx)
                  EXT_WEN:   begin wen <= 1'b1; state <= ST_HOLD; end
                  EXT_WDIS:  begin wen <= 1'b0; state <= ST_HOLD; end
                  EXT_WRALL: begin kind <= PK_WRALL; state <= ST_DATA; end
                  default:   begin kind <= PK_ERALL; state <= ST_ARMED; end
                endcase
              end
            endcase
          end
        end
        ST_DATA: begin
          dsr <= {dsr[WORD_W-2:0], di};
          cnt <= cnt + 1'b1;
          if (cnt == WORD_LAST) state <= ST_ARMED;
        end
        ST_READ: begin
          if (cnt != WORD_CNT) begin
            rbit <= dsr[WORD_W-1];
            dsr  <= {dsr[WORD_W-2:0], 1'b0};
            cnt  <= cnt + 1'b1;
          end
        end
        ST_ARMED: state <= ST_HOLD;
        default:  state <= state;
      endcase
    end
  end
endmodule

// File: rtl/mwe_prog_timer.sv
module mwe_prog_timer #(
  parameter int PROG_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

  logic [CW-1:0] left;

  assign done = busy & (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      left <= LOAD;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/mwe_eeprom.sv
module mwe_eeprom import mwe_pkg::*; #(
  parameter int ADDR_W      = 6,
  parameter int WORD_W      = 16,
  parameter int PROG_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout,
  output logic dout_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              sk_rise, cs_fall;
  logic              launch, start_seen, rd_active, rd_bit, fsm_idle;
  logic              busy, done;
  logic [ADDR_W-1:0] rd_addr, prog_addr;
  logic [WORD_W-1:0] wdata, rdata;
  prog_t             launch_kind;

  prog_t             p_kind;
  logic [ADDR_W-1:0] p_addr;
  logic [WORD_W-1:0] p_data;
  logic              status_q;
  logic              all_words;
  logic [WORD_W-1:0] fill;
  logic [DEPTH*WORD_W-1:0] flat;

  mwe_pin_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk),
    .sk_rise(sk_rise), .cs_fall(cs_fall)
  );

  mwe_cmd_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk_rise(sk_rise), .cs_fall(cs_fall),
    .di(di), .busy(busy), .rdata(rdata), .rd_addr(rd_addr),
    .prog_addr(prog_addr), .wdata(wdata), .launch_kind(launch_kind),
    .launch(launch), .start_seen(start_seen), .rd_active(rd_active),
    .rd_bit(rd_bit), .idle(fsm_idle)
  );

  mwe_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(launch), .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_kind   <= PK_WRITE;
      p_addr   <= '0;
      p_data   <= '0;
      status_q <= 1'b0;
    end else begin
      if (launch) begin
        p_kind   <= launch_kind;
        p_addr   <= prog_addr;
        p_data   <= wdata;
        status_q <= 1'b1;
      end else if (start_seen) begin
        status_q <= 1'b0;
      end
    end
  end

  assign all_words = (p_kind == PK_WRALL) || (p_kind == PK_ERALL);
  assign fill      = ((p_kind == PK_WRITE) || (p_kind == PK_WRALL)) ? p_data : '1;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit;
    assign hit = all_words || (p_addr == ADDR_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           word_q <= '0;
      else if (done && hit) word_q <= fill;
    end
    assign flat[gi*WORD_W +: WORD_W] = word_q;
  end

  assign rdata   = flat[rd_addr*WORD_W +: WORD_W];
  assign dout_oe = cs & (rd_active | status_q);
  assign dout    = rd_active ? rd_bit : ~busy;
endmodule

// File: rtl/mwe_checker.sv
module mwe_checker #(
  parameter int PROG_CYCLES = 50
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic dout,
  input logic dout_oe,
  input logic busy,
  input logic fsm_idle,
  input logic status
);
  localparam int RW = $clog2(PROG_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  p_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !dout_oe);

  p_busy_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && busy) |-> (dout_oe && !dout));

  p_ready_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && status && !busy) |-> (dout_oe && dout));

  p_launch_on_cs_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(cs) && $past(cs, 2)));

  p_busy_length_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == RW'(PROG_CYCLES)));

  p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < RW'(PROG_CYCLES)));

  p_discard_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> fsm_idle);
endmodule

bind mwe_eeprom mwe_checker #(.PROG_CYCLES(PROG_CYCLES)) u_mwe_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .dout_oe(dout_oe),
  .busy(busy), .fsm_idle(fsm_idle), .status(status_q)
);

// File: tb/mwe_eeprom_test.sv
module mwe_eeprom_test;
  localparam int PROG = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, dout_oe;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  mwe_eeprom #(.ADDR_W(6), .WORD_W(16), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .dout(dout), .dout_oe(dout_oe)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_mem [64];
  bit   m_bits [$];
  bit   m_out [$];
  int   m_left, m_phase, m_kind, m_pkind;
  bit   m_wen, m_stat, m_rd_on, m_do, m_sk, m_cs;
  bit   m_rise, m_fall, m_wb;
  logic [5:0]  m_addr, m_paddr;
  logic [15:0] m_data, m_pdata;
  logic [1:0]  m_op;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 64; k++) m_mem[k] = 16'h0000;
      m_bits.delete(); m_out.delete();
      m_left = 0; m_phase = 0; m_kind = 0; m_pkind = 0;
      m_wen = 0; m_stat = 0; m_rd_on = 0; m_do = 0; m_sk = 0; m_cs = 0;
    end else begin
      m_rise = sk && !m_sk;
      m_fall = !cs && m_cs;
      m_wb   = (m_left > 0);
      if (m_wb) begin
        m_left--;
        if (m_left == 0) begin
          case (m_pkind)
            1: m_mem[m_paddr] = m_pdata;
            2: m_mem[m_paddr] = 16'hFFFF;
            3: for (int k = 0; k < 64; k++) m_mem[k] = m_pdata;
            default: for (int k = 0; k < 64; k++) m_mem[k] = 16'hFFFF;
          endcase
        end
      end
      if (!cs) begin
        if (m_fall && m_phase == 3 && m_wen && !m_wb) begin
          m_left = PROG; m_stat = 1;
          m_pkind = m_kind; m_paddr = m_addr; m_pdata = m_data;
        end
        m_phase = 0; m_rd_on = 0;
      end else if (m_rise && !m_wb) begin
        case (m_phase)
          0: if (di) begin m_phase = 1; m_stat = 0; m_bits.delete(); end
          1: begin
            m_bits.push_back(di);
            if (m_bits.size() == 8) begin
              m_op = {m_bits[0], m_bits[1]};
              m_addr = '0;
              for (int k = 2; k < 8; k++) m_addr = {m_addr[4:0], m_bits[k]};
              case (m_op)
                2'b10: begin
                  m_phase = 2; m_rd_on = 1; m_do = 0; m_out.delete();
                  for (int b = 15; b >= 0; b--) m_out.push_back(m_mem[m_addr][b]);
                end
                2'b01: m_kind = 1;
                2'b11: begin m_kind = 2; m_phase = 3; end
                default: case (m_addr[5:4])
                  2'b11: begin m_wen = 1; m_phase = 4; end
                  2'b00: begin m_wen = 0; m_phase = 4; end
                  2'b01: m_kind = 3;
                  default: begin m_kind = 4; m_phase = 3; end
                endcase
              endcase
            end else if (m_bits.size() == 24) begin
              m_data = '0;
              for (int k = 8; k < 24; k++) m_data = {m_data[14:0], m_bits[k]};
              m_phase = 3;
            end
          end
          2: if (m_out.size() > 0) m_do = m_out.pop_front();
          3: m_phase = 4;
          default: ;
        endcase
      end
      m_sk = sk; m_cs = cs;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_oe, e_do;
      e_oe = cs && (m_rd_on || m_stat);
      e_do = m_rd_on ? m_do : (m_left == 0);
      checks++;
      if (dout_oe !== e_oe || (e_oe && dout !== e_do)) begin
        fails++;
        $display("FAIL %s cycle compare: oe=%b do=%b expected oe=%b do=%b",
                 cur_req, dout_oe, dout, e_oe, e_do);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drv(input bit c, input bit s, input bit d, input int n);
    @(negedge clk); #1;
    cs = c; sk = s; di = d;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic clk_bit(input bit b);
    drv(1, 0, b, 2);
    drv(1, 1, b, 2);
  endtask

  task automatic cmd(input logic [1:0] op, input logic [5:0] a);
    clk_bit(1);
    for (int k = 1; k >= 0; k--) clk_bit(op[k]);
    for (int k = 5; k >= 0; k--) clk_bit(a[k]);
  endtask

  task automatic data16(input logic [15:0] w);
    for (int k = 15; k >= 0; k--) clk_bit(w[k]);
  endtask

  task automatic prog_wait();
    drv(0, 0, 0, PROG + 5);
  endtask

  task automatic look(input string req, input bit e_oe, input bit e_do);
    drv(1, 0, 0, 3);
    chk(req, {14'b0, dout_oe, dout_oe ? dout : 1'b0}, {14'b0, e_oe, e_oe ? e_do : 1'b0});
  endtask

  task automatic read_word(input logic [5:0] a, output logic [15:0] w,
                           output logic dummy, output logic held);
    cmd(2'b10, a);
    dummy = dout;
    w = '0;
    for (int k = 0; k < 16; k++) begin
      clk_bit(0);
      w = {w[14:0], dout};
    end
    clk_bit(0);
    held = dout;
    drv(0, 0, 0, 2);
  endtask

  logic [15:0] rw;
  logic        rdum, rhold;

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;

    cur_req = "R1";
    look("R1 output enable after reset", 0, 0);
    drv(0, 0, 0, 2);

    cur_req = "R6";
    cmd(2'b01, 6'd5); data16(16'h1234); prog_wait();
    look("R6 no status while write-disabled", 0, 0);
    drv(0, 0, 0, 2);
    read_word(6'd5, rw, rdum, rhold);
    chk("R6 word unchanged while write-disabled", rw, 16'h0000);

    cur_req = "R2";
    cmd(2'b00, 6'b110000); drv(0, 0, 0, 2);

    cur_req = "R7";
    cmd(2'b01, 6'd5); data16(16'hA5C3);
    drv(0, 0, 0, 3);
    look("R7 busy shows low", 1, 0);
    drv(0, 0, 0, 2);
    look("R7 busy after select toggle", 1, 0);
    cur_req = "R9";
    cmd(2'b00, 6'b000000);
    look("R9 still busy after discarded command", 1, 0);
    drv(0, 0, 0, PROG);

    cur_req = "R8";
    look("R8 ready shows high", 1, 1);
    drv(0, 0, 0, 2);
    look("R8 ready persists across select toggle", 1, 1);

    cur_req = "R3";
    read_word(6'd5, rw, rdum, rhold);
    chk("R4 written word", rw, 16'hA5C3);
    chk("R3 dummy bit", {15'b0, rdum}, 16'h0000);
    chk("R3 last bit held", {15'b0, rhold}, 16'h0001);
    look("R8 start bit cleared ready status", 0, 0);
    drv(0, 0, 0, 2);

    cur_req = "R4";
    cmd(2'b01, 6'd5); data16(16'h0F0F); prog_wait();
    read_word(6'd5, rw, rdum, rhold);
    chk("R9 discarded write-disable; R4 overwrite without erase", rw, 16'h0F0F);

    cur_req = "R5";
    cmd(2'b11, 6'd5); prog_wait();
    read_word(6'd5, rw, rdum, rhold);
    chk("R5 erase word", rw, 16'hFFFF);
    cmd(2'b00, 6'b010000); data16(16'h3C3C); prog_wait();
    read_word(6'd0, rw, rdum, rhold);
    chk("R5 write-all word 0", rw, 16'h3C3C);
    read_word(6'd63, rw, rdum, rhold);
    chk("R5 write-all word 63", rw, 16'h3C3C);
    cmd(2'b00, 6'b100000); prog_wait();
    read_word(6'd17, rw, rdum, rhold);
    chk("R5 erase-all word 17", rw, 16'hFFFF);

    cur_req = "R10";
    cmd(2'b01, 6'd2); data16(16'h1111); clk_bit(0); prog_wait();
    look("R10 no busy after cancelled command", 0, 0);
    drv(0, 0, 0, 2);
    read_word(6'd2, rw, rdum, rhold);
    chk("R10 cancelled write left word", rw, 16'hFFFF);

    cur_req = "R6";
    cmd(2'b00, 6'b000000); drv(0, 0, 0, 2);
    cmd(2'b01, 6'd9); data16(16'h7777); prog_wait();
    look("R6 no status after write-disable", 0, 0);
    drv(0, 0, 0, 2);

    cur_req = "R2";
    clk_bit(0); clk_bit(0);
    read_word(6'd9, rw, rdum, rhold);
    chk("R2 leading zeros ignored; R6 word kept", rw, 16'hFFFF);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule